// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel ports, A and B, and moves data between them in either direction. The width is split into independent sections, two 8-bit sections by default. Each section has its own output enable, direction, select and capture-clock inputs. Driving the same controls to every section makes the block act as a single 16-bit path.

Each section has two storage registers. The forward register samples the A-port input on the rising edge of that section's forward capture clock. The reverse register samples the B-port input on the rising edge of that section's reverse capture clock.

The driven port carries one of two values, chosen per direction by a select input:
- live data taken from the opposite port's input, or
- the value held in the register for that direction.

Each port is modelled as three vectors: an input, a data output and a per-bit output enable. No tristate nets are used. Outputs are combinational in the controls, the port inputs and the register contents, so enable, direction and select changes take effect without a clock. The registers keep loading while the outputs are isolated and while data is being transmitted.

Top module: `regbus_xcvr`

## Requirements
- R1: In section s, the forward register takes aIn bits [8s+7:8s] on each rising edge of clkAB[s]. The reverse register takes bIn bits [8s+7:8s] on each rising edge of clkBA[s].
- R2: While oeN[s] is 1, the section-s bits of aOe and bOe are all 0. The registers still load on their clock edges, and the loaded values appear once the section is enabled.
- R3: While oeN[s] is 0, dirAtoB[s]=1 sets the section-s bits of bOe to all ones and of aOe to all zeros. dirAtoB[s]=0 does the reverse. A and B are never enabled together in a section.
- R4: When B is driven, selAB[s]=1 puts the forward register on bOut and selAB[s]=0 puts live aIn there. When A is driven, selBA[s]=1 puts the reverse register on aOut and selBA[s]=0 puts live bIn there.
- R5: The data-output bits of a port whose enable bits are 0 read as zero.
- R6: Either register, or both on the same edge, can load while the section is transmitting.
- R7: The controls of section s affect only bits [8s+7:8s]. Equal controls on all sections behave as one full-width path.
- R8: When a select input changes, the output moves directly from one source value to the other, with no clock edge and no intermediate value.
- R9: rstN=0 clears every register to zero at once, without a clock.
- R10: Changes of oeN and dirAtoB alter the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low register clear |
| oeN | input | 2 | Per-section output enable, active low |
| dirAtoB | input | 2 | Per-section direction, 1 = A drives B |
| selAB | input | 2 | Per-section B-side source, 1 = stored |
| selBA | input | 2 | Per-section A-side source, 1 = stored |
| clkAB | input | 2 | Per-section forward register clock |
| clkBA | input | 2 | Per-section reverse register clock |
| aIn | input | 16 | A-port input data |
| aOut | output | 16 | A-port output data |
| aOe | output | 16 | A-port per-bit output enable |
| bIn | input | 16 | B-port input data |
| bOut | output | 16 | B-port output data |
| bOe | output | 16 | B-port per-bit output enable |

## Verification
The hardest case to reach is a register value that was loaded while its section was isolated or pointed the other way, and is observed only later through the stored select. A wrong capture stays invisible until that later moment.

The stimulus handles this in two ways. Random cycles draw the capture clocks independently of the enables and selects. Directed steps load both registers during isolation, then enable each direction with the stored select. Further directed steps toggle the selects and the enable in the middle of a cycle, with no capture edge, to show that the output switches straight to the new source.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic drvA;
    logic drvB;
    logic storedToB;
    logic storedToA;
  } laneStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int NUM_SEC = 2
) (
  input  logic [NUM_SEC-1:0] oeN,
  input  logic [NUM_SEC-1:0] dirAtoB,
  input  logic [NUM_SEC-1:0] selAB,
  input  logic [NUM_SEC-1:0] selBA,
  output laneStrobe_t [NUM_SEC-1:0] strobes
);
  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    always_comb begin
      strobes[s].drvB      = !oeN[s] && dirAtoB[s];
      strobes[s].drvA      = !oeN[s] && !dirAtoB[s];
      strobes[s].storedToB = selAB[s];
      strobes[s].storedToA = selBA[s];
    end
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int NUM_SEC = 2,
  parameter int SEC_W   = 8,
  localparam int BUS_W  = NUM_SEC * SEC_W
) (
  input  logic                rstN,
  input  logic [NUM_SEC-1:0]  clkAB,
  input  logic [NUM_SEC-1:0]  clkBA,
  input  laneStrobe_t [NUM_SEC-1:0] strobes,
  input  logic [BUS_W-1:0]    aIn,
  input  logic [BUS_W-1:0]    bIn,
  output logic [BUS_W-1:0]    aOut,
  output logic [BUS_W-1:0]    aOe,
  output logic [BUS_W-1:0]    bOut,
  output logic [BUS_W-1:0]    bOe
);
  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic [SEC_W-1:0] regAB, regBA;
    logic armAB, armBA;
    logic [SEC_W-1:0] aSec, bSec;
    assign aSec = aIn[s*SEC_W +: SEC_W];
    assign bSec = bIn[s*SEC_W +: SEC_W];

    always_ff @(posedge clkAB[s] or negedge rstN) begin
      if (!rstN) begin
        regAB <= '0;
        armAB <= 1'b0;
      end else begin
        regAB <= aSec;
        armAB <= 1'b1;
      end
    end

    always_ff @(posedge clkBA[s] or negedge rstN) begin
      if (!rstN) begin
        regBA <= '0;
        armBA <= 1'b0;
      end else begin
        regBA <= bSec;
        armBA <= 1'b1;
      end
    end

    // Single-level select per bit: output switches straight between sources
    always_comb begin
      bOe[s*SEC_W +: SEC_W]  = {SEC_W{strobes[s].drvB}};
      aOe[s*SEC_W +: SEC_W]  = {SEC_W{strobes[s].drvA}};
      bOut[s*SEC_W +: SEC_W] = '0;
      aOut[s*SEC_W +: SEC_W] = '0;
      if (strobes[s].drvB)
        bOut[s*SEC_W +: SEC_W] = strobes[s].storedToB ? regAB : aSec;
      if (strobes[s].drvA)
        aOut[s*SEC_W +: SEC_W] = strobes[s].storedToA ? regBA : bSec;
    end

    // R1: forward register holds what A carried at the previous capture edge
    p_capture_ab_r1: assert property (@(posedge clkAB[s]) disable iff (!rstN)
      armAB |-> regAB == $past(aSec));
    // R1: reverse register holds what B carried at the previous capture edge
    p_capture_ba_r1: assert property (@(posedge clkBA[s]) disable iff (!rstN)
      armBA |-> regBA == $past(bSec));
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int NUM_SEC = 2,
  parameter int SEC_W   = 8,
  localparam int BUS_W  = NUM_SEC * SEC_W
) (
  input  logic               rstN,
  input  logic [NUM_SEC-1:0] oeN,
  input  logic [NUM_SEC-1:0] dirAtoB,
  input  logic [NUM_SEC-1:0] selAB,
  input  logic [NUM_SEC-1:0] selBA,
  input  logic [NUM_SEC-1:0] clkAB,
  input  logic [NUM_SEC-1:0] clkBA,
  input  logic [BUS_W-1:0]   aIn,
  output logic [BUS_W-1:0]   aOut,
  output logic [BUS_W-1:0]   aOe,
  input  logic [BUS_W-1:0]   bIn,
  output logic [BUS_W-1:0]   bOut,
  output logic [BUS_W-1:0]   bOe
);
  laneStrobe_t [NUM_SEC-1:0] strobes;

  xcvr_ctrl #(.NUM_SEC(NUM_SEC)) u_ctrl (
    .oeN(oeN), .dirAtoB(dirAtoB), .selAB(selAB), .selBA(selBA), .strobes(strobes)
  );

  xcvr_datapath #(.NUM_SEC(NUM_SEC), .SEC_W(SEC_W)) u_dp (
    .rstN(rstN), .clkAB(clkAB), .clkBA(clkBA), .strobes(strobes),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_chk
    p_isolate_r2: assert property (@(posedge clkAB[s]) disable iff (!rstN)
      oeN[s] |-> (aOe[s*SEC_W +: SEC_W] == '0 && bOe[s*SEC_W +: SEC_W] == '0));
    p_one_port_r3: assert property (@(posedge clkAB[s]) disable iff (!rstN)
      !((|aOe[s*SEC_W +: SEC_W]) && (|bOe[s*SEC_W +: SEC_W])));
    p_idle_a_zero_r5: assert property (@(posedge clkBA[s]) disable iff (!rstN)
      (aOe[s*SEC_W +: SEC_W] == '0) |-> (aOut[s*SEC_W +: SEC_W] == '0));
    p_idle_b_zero_r5: assert property (@(posedge clkBA[s]) disable iff (!rstN)
      (bOe[s*SEC_W +: SEC_W] == '0) |-> (bOut[s*SEC_W +: SEC_W] == '0));
  end
endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
  localparam int NS = 2;
  localparam int W  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [NS-1:0] oeN, dirAtoB, selAB, selBA, clkAB, clkBA;
  logic [NS*W-1:0] aIn, bIn, aOut, aOe, bOut, bOe;

  regbus_xcvr u_dut (
    .rstN(rstN), .oeN(oeN), .dirAtoB(dirAtoB), .selAB(selAB), .selBA(selBA),
    .clkAB(clkAB), .clkBA(clkBA), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  int errors = 0;
  int checks = 0;
  logic [W-1:0] mAB[NS];
  logic [W-1:0] mBA[NS];

  task automatic check(input string req, input logic [NS*W-1:0] act, input logic [NS*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: per-section expected port outputs from the requirements
  task automatic compare(input string req);
    logic [NS*W-1:0] eAO, eAE, eBO, eBE;
    eAO = '0; eAE = '0; eBO = '0; eBE = '0;
    for (int s = 0; s < NS; s++) begin
      if (!oeN[s] && dirAtoB[s]) begin
        eBE[s*W +: W] = '1;
        eBO[s*W +: W] = selAB[s] ? mAB[s] : aIn[s*W +: W];
      end else if (!oeN[s]) begin
        eAE[s*W +: W] = '1;
        eAO[s*W +: W] = selBA[s] ? mBA[s] : bIn[s*W +: W];
      end
    end
    check({req, " aOe"}, aOe, eAE);
    check({req, " bOe"}, bOe, eBE);
    check({req, " aOut"}, aOut, eAO);
    check({req, " bOut"}, bOut, eBO);
  endtask

  // One bench cycle: capture pulses at +3ns, comparison at +5ns
  task automatic cycle(input logic [NS-1:0] cAB, input logic [NS-1:0] cBA, input string req);
    #2;
    clkAB = cAB; clkBA = cBA;
    for (int s = 0; s < NS; s++) begin
      if (cAB[s]) mAB[s] = aIn[s*W +: W];
      if (cBA[s]) mBA[s] = bIn[s*W +: W];
    end
    #2;
    compare(req);
    #1;
    clkAB = '0; clkBA = '0;
  endtask

  task automatic setup(input logic [NS-1:0] o, input logic [NS-1:0] d,
                       input logic [NS-1:0] sa, input logic [NS-1:0] sb,
                       input logic [NS*W-1:0] a, input logic [NS*W-1:0] b);
    @(posedge clk); #1;
    oeN = o; dirAtoB = d; selAB = sa; selBA = sb; aIn = a; bIn = b;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; oeN = '1; dirAtoB = '0; selAB = '0; selBA = '0;
    clkAB = '0; clkBA = '0; aIn = '0; bIn = '0;
    for (int s = 0; s < NS; s++) begin mAB[s] = '0; mBA[s] = '0; end
    repeat (3) @(posedge clk);
    #1;
    compare("R2 R5 reset isolation");
    rstN = 1'b1;

    // R9: stored paths show zero after reset
    setup(2'b00, 2'b11, 2'b11, 2'b11, 16'hA5C3, 16'h1234);
    cycle('0, '0, "R9 reset clears forward regs");
    setup(2'b00, 2'b00, 2'b11, 2'b11, 16'hA5C3, 16'h1234);
    cycle('0, '0, "R9 reset clears reverse regs");

    // R2: load while isolated, then show via stored select
    setup(2'b11, 2'b00, 2'b11, 2'b11, 16'h3C7E, 16'hD00F);
    cycle('1, '1, "R2 R1 capture while isolated");
    setup(2'b00, 2'b11, 2'b11, 2'b11, 16'h0000, 16'hFFFF);
    cycle('0, '0, "R2 R4 stored forward after isolation");
    check("R4 stored forward value", bOut, 16'h3C7E);
    setup(2'b00, 2'b00, 2'b11, 2'b11, 16'h0000, 16'hFFFF);
    cycle('0, '0, "R2 R4 stored reverse after isolation");
    check("R4 stored reverse value", aOut, 16'hD00F);

    // R6: both regs load while transmitting A to B
    setup(2'b00, 2'b11, 2'b00, 2'b00, 16'h1357, 16'h2468);
    cycle('1, '1, "R6 dual capture while transmitting");
    setup(2'b00, 2'b11, 2'b11, 2'b00, 16'h0, 16'h0);
    cycle('0, '0, "R6 R1 forward captured");
    setup(2'b00, 2'b00, 2'b00, 2'b11, 16'h0, 16'h0);
    cycle('0, '0, "R6 R1 reverse captured");
    check("R6 reverse value", aOut, 16'h2468);

    // R7: mixed sections, one each way
    setup(2'b00, 2'b01, 2'b01, 2'b00, 16'hAB12, 16'hCD34);
    cycle(2'b10, 2'b01, "R7 independent sections");
    // R7: ganged full width
    setup(2'b00, 2'b11, 2'b00, 2'b00, 16'hBEEF, 16'h0);
    cycle('0, '0, "R7 ganged path");
    check("R7 ganged live value", bOut, 16'hBEEF);

    // R8: select flip mid-cycle, no clock
    setup(2'b00, 2'b11, 2'b00, 2'b00, 16'h5A5A, 16'h0);
    cycle(2'b11, 2'b00, "R8 prepare");
    aIn = 16'h9999;
    #1; check("R8 live before flip", bOut, 16'h9999);
    selAB = 2'b11;
    #1; check("R8 stored right after flip", bOut, 16'h5A5A);
    selAB = 2'b00;
    #1; check("R8 live right after flip back", bOut, 16'h9999);

    // R10: enable/direction change without a clock
    oeN = 2'b11;
    #1; check("R10 disable without clock", bOe, 16'h0);
    oeN = 2'b00; dirAtoB = 2'b00; bIn = 16'h7777; selBA = 2'b00;
    #1; check("R10 direction change without clock", aOut, 16'h7777);
    check("R10 B released", bOe, 16'h0);

    // Random cycles against the reference model
    for (int i = 0; i < 400; i++) begin
      setup(NS'($urandom), NS'($urandom), NS'($urandom), NS'($urandom),
            (NS*W)'($urandom), (NS*W)'($urandom));
      cycle(NS'($urandom), NS'($urandom), "R1 R3 R4 R5 random");
    end

    // R9: asynchronous clear mid-run
    #1; rstN = 1'b0;
    #1; for (int s = 0; s < NS; s++) begin mAB[s] = '0; mBA[s] = '0; end
    rstN = 1'b1;
    setup(2'b00, 2'b11, 2'b11, 2'b11, 16'hFFFF, 16'hFFFF);
    cycle('0, '0, "R9 async clear mid-run");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule